// File: doc/BRIEF.md
# Dual-Channel Wiper Position and Stored-Setting Bank

This block holds the digital control state for two potentiometer channels. Each channel owns a volatile wiper position register and four setting registers that stand in for nonvolatile storage. The wiper position is decoded into a one-hot enable for 256 tap switches. The analog resistor array that uses this enable is outside the block.

Commands arrive on a valid/ready command stream that carries an opcode, a channel, a register index and a data byte. A command is accepted on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. Read commands return one byte on a valid/ready response stream. The block holds one response at most, so `cmd_ready` stays low while a response waits. A waiting response keeps its data stable until `rsp_ready` takes it.

Any accepted write to a setting register starts a timed write cycle. The `wip` flag reports this cycle. The write-protect input `wp_n` gates all such writes. There are two reset inputs. `por_n` is the power-on reset, which also restores the stored settings. `rst_n` is a warm reset, which reloads each wiper from its channel's setting 0.

Top module: `wpot_bank`

## Requirements
- R1: While `por_n` is low, every setting register and every wiper is set to `DR_INIT` (default 80h). While `rst_n` is low and `por_n` is high, each wiper is loaded from setting 0 of its own channel, and the setting registers keep their contents.
- R2: Opcode 0 (load wiper) sets the wiper of channel `cmd_ch` to `cmd_data`. The new value is visible one clock after acceptance.
- R3: Opcode 4 (recall) copies setting `cmd_reg` of channel `cmd_ch` into that channel's wiper.
- R4: Opcode 6 (step) moves the selected wiper by one position. Bit 0 of `cmd_data` gives the direction: 1 steps up, 0 steps down. The wiper saturates at FFh going up and at 00h going down.
- R5: Opcode 2 (store byte) writes `cmd_data` into setting `cmd_reg` of channel `cmd_ch`. Opcode 5 (save) writes the channel's current wiper into that setting. Both take effect only while `wp_n` is high and `wip` is low.
- R6: An accepted store or save raises `wip` on the next clock. `wip` then stays high for exactly `WR_CYCLES` clocks.
- R7: While `wp_n` is low, store and save commands are accepted but change no setting register and do not raise `wip`.
- R8: Store and save commands accepted while `wip` is high change no setting register and do not extend the write cycle.
- R9: Opcodes 1 (read wiper), 3 (read setting) and 7 (read status) raise `rsp_valid` one clock after acceptance. The status byte carries `wip` in bit 0 and zeros in all other bits. Other opcodes produce no response.
- R10: `cmd_ready` is low while `rsp_valid` is high or while either reset is asserted. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays unchanged.
- R11: Each channel's tap select has exactly one bit set, at the index equal to its wiper value. Value 00h selects bit 0, the low terminal. Value FFh selects bit 255, the high terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; restores stored settings |
| rst_n | input | 1 | Warm reset, active low, synchronous; reloads wipers from setting 0 |
| wp_n | input | 1 | Write protect, active low; blocks setting writes |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 3 | Command opcode |
| cmd_ch | input | CHW (1) | Channel index |
| cmd_reg | input | RW (2) | Setting register index |
| cmd_data | input | W (8) | Command data byte |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_data | output | W (8) | Response byte |
| wip | output | 1 | Write cycle in progress |
| wiper_pos | output | NCH*W (16) | Wiper positions, channel 0 in the low byte |
| tap_sel | output | NCH*TAPS (512) | One-hot tap enables, channel 0 in the low 256 bits |

## Verification
Every command result is due exactly one clock after the accepting edge: wiper values, tap selects, setting contents, the rise of `wip` and `rsp_valid`. The end of a write cycle is due `WR_CYCLES` clocks after that. The bench keeps a behavioural model that advances on the same rising edge as the design. It drives inputs and compares all outputs on the falling edge, so every result is checked in the cycle it becomes due. Directed checks also count the number of high `wip` cycles and hold a response under back-pressure to confirm it stays stable.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
  typedef enum logic [2:0] {
    OP_LOAD_WIPER = 3'd0,
    OP_READ_WIPER = 3'd1,
    OP_STORE_BYTE = 3'd2,
    OP_READ_SET   = 3'd3,
    OP_RECALL     = 3'd4,
    OP_SAVE       = 3'd5,
    OP_STEP       = 3'd6,
    OP_READ_STAT  = 3'd7
  } op_e;
endpackage

// File: rtl/wpot_nvtimer.sv
module wpot_nvtimer #(
  parameter int CYCLES = 1250000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)             cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6
  wip_start_chk: assert property (@(posedge clk) disable iff (clr)
    start |=> busy);
  // R8
  wip_idle_chk: assert property (@(posedge clk) disable iff (clr)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/wpot_wiper.sv
module wpot_wiper #(
  parameter int W = 8,
  localparam int TAPS = 1 << W
) (
  input  logic            clk,
  input  logic            rst_ld,
  input  logic [W-1:0]    rst_val,
  input  logic            ld_en,
  input  logic [W-1:0]    ld_val,
  input  logic            step_en,
  input  logic            step_up,
  output logic [W-1:0]    pos,
  output logic [TAPS-1:0] tap
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst_ld)       pos <= rst_val;
    else if (ld_en)   pos <= ld_val;
    else if (step_en) begin
      if (step_up && pos != TOP)       pos <= pos + 1'b1;
      else if (!step_up && pos != '0)  pos <= pos - 1'b1;
    end
  end

  always_comb begin
    tap = '0;
    tap[pos] = 1'b1;
  end

  // R4
  step_top_chk: assert property (@(posedge clk) disable iff (rst_ld)
    (step_en && !ld_en && step_up && pos == TOP) |=> pos == TOP);
  // R4
  step_bot_chk: assert property (@(posedge clk) disable iff (rst_ld)
    (step_en && !ld_en && !step_up && pos == '0) |=> pos == '0);
  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst_ld)
    ld_en |=> pos == $past(ld_val));
  // R11
  tap_onehot_chk: assert property (@(posedge clk) disable iff (rst_ld)
    $countones(tap) == 1);
endmodule

// File: rtl/wpot_bank.sv
module wpot_bank #(
  parameter int NCH = 2,
  parameter int W = 8,
  parameter int NDR = 4,
  parameter logic [7:0] DR_INIT = 8'h80,
  parameter int WR_CYCLES = 1250000,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 wp_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [2:0]           cmd_op,
  input  logic [CHW-1:0]       cmd_ch,
  input  logic [RW-1:0]        cmd_reg,
  input  logic [W-1:0]         cmd_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [W-1:0]         rsp_data,
  output logic                 wip,
  output logic [NCH*W-1:0]     wiper_pos,
  output logic [NCH*TAPS-1:0]  tap_sel
);
  import wpot_pkg::*;

  op_e          op;
  logic         any_rst, acc, nv_req, nv_go, is_read;
  logic [W-1:0] nv_val, rd_val;
  logic [W-1:0] dr  [NCH][NDR];
  logic [W-1:0] pos [NCH];

  assign op        = op_e'(cmd_op);
  assign any_rst   = !por_n || !rst_n;
  assign cmd_ready = !rsp_valid && !any_rst;
  assign acc       = cmd_valid && cmd_ready;
  assign nv_req    = acc && (op == OP_STORE_BYTE || op == OP_SAVE);
  assign nv_go     = nv_req && wp_n && !wip;
  assign nv_val    = (op == OP_STORE_BYTE) ? cmd_data : pos[cmd_ch];
  assign is_read   = (op == OP_READ_WIPER) || (op == OP_READ_SET) || (op == OP_READ_STAT);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NDR; r++)
          dr[c][r] <= W'(DR_INIT);
    end else if (nv_go) begin
      dr[cmd_ch][cmd_reg] <= nv_val;
    end
  end

  wpot_nvtimer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .clr(any_rst), .start(nv_go), .busy(wip)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = (cmd_ch == CHW'(c));
    wpot_wiper #(.W(W)) u_wiper (
      .clk     (clk),
      .rst_ld  (any_rst),
      .rst_val (!por_n ? W'(DR_INIT) : dr[c][0]),
      .ld_en   (acc && sel && (op == OP_LOAD_WIPER || op == OP_RECALL)),
      .ld_val  ((op == OP_LOAD_WIPER) ? cmd_data : dr[c][cmd_reg]),
      .step_en (acc && sel && op == OP_STEP),
      .step_up (cmd_data[0]),
      .pos     (pos[c]),
      .tap     (tap_sel[c*TAPS +: TAPS])
    );
    assign wiper_pos[c*W +: W] = pos[c];
  end

  always_comb begin
    unique case (op)
      OP_READ_WIPER: rd_val = pos[cmd_ch];
      OP_READ_SET:   rd_val = dr[cmd_ch][cmd_reg];
      default:       rd_val = {{(W-1){1'b0}}, wip};
    endcase
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && is_read) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R10
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (any_rst)
    rsp_valid |-> !cmd_ready);
  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (any_rst)
    (nv_req && !wp_n && !wip) |=> !wip);
  // R9
  rsp_rise_chk: assert property (@(posedge clk) disable iff (any_rst)
    (acc && is_read) |=> rsp_valid);
endmodule

// File: tb/tb_wpot_bank.sv
module tb_wpot_bank;
  localparam int NCH = 2, W = 8, NDR = 4, TAPS = 256, WRC = 20;
  localparam logic [7:0] INIT = 8'h80;

  logic clk = 0, por_n = 0, rst_n = 0, wp_n = 1;
  logic cmd_valid = 0, rsp_ready = 1;
  logic [2:0] cmd_op = 0;
  logic [0:0] cmd_ch = 0;
  logic [1:0] cmd_reg = 0;
  logic [7:0] cmd_data = 0;
  logic cmd_ready, rsp_valid, wip;
  logic [7:0] rsp_data;
  logic [NCH*W-1:0] wiper_pos;
  logic [NCH*TAPS-1:0] tap_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wpot_bank #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wip(wip), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
  );

  // behavioural reference model
  int m_dr [2][4];
  int m_wp [2];
  int m_cnt = 0;
  bit m_rv = 0;
  int m_rd = 0;

  always @(posedge clk) begin
    bit acc;
    acc = cmd_valid && !m_rv && por_n && rst_n;
    if (!por_n) begin
      foreach (m_dr[c, r]) m_dr[c][r] = INIT;
      m_wp[0] = INIT; m_wp[1] = INIT; m_cnt = 0; m_rv = 0; m_rd = 0;
    end else if (!rst_n) begin
      m_wp[0] = m_dr[0][0]; m_wp[1] = m_dr[1][0]; m_cnt = 0; m_rv = 0; m_rd = 0;
    end else begin
      int busy, ch, rg;
      busy = (m_cnt != 0);
      ch = cmd_ch; rg = cmd_reg;
      if (m_cnt > 0) m_cnt--;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc) begin
        case (cmd_op)
          0: m_wp[ch] = cmd_data;
          1: begin m_rv = 1; m_rd = m_wp[ch]; end
          2, 5: if (wp_n && !busy) begin
                  m_dr[ch][rg] = (cmd_op == 2) ? int'(cmd_data) : m_wp[ch];
                  m_cnt = WRC;
                end
          3: begin m_rv = 1; m_rd = m_dr[ch][rg]; end
          4: m_wp[ch] = m_dr[ch][rg];
          6: if (cmd_data[0]) begin if (m_wp[ch] < 255) m_wp[ch]++; end
             else if (m_wp[ch] > 0) m_wp[ch]--;
          default: begin m_rv = 1; m_rd = busy; end
        endcase
      end
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) begin
      logic [TAPS-1:0] exp_tap;
      exp_tap = '0;
      exp_tap[m_wp[c]] = 1'b1;
      chk("R2 wiper value", wiper_pos[c*W +: W], m_wp[c]);
      n_chk++;
      if (tap_sel[c*TAPS +: TAPS] !== exp_tap) begin
        n_bad++;
        $display("FAIL R11 tap ch%0d: got bit %0d expected bit %0d", c,
                 $clog2(tap_sel[c*TAPS +: TAPS]), m_wp[c]);
      end
    end
    chk("R6 wip", wip, m_cnt != 0);
    chk("R10 cmd_ready", cmd_ready, !m_rv && por_n && rst_n);
    chk("R9 rsp_valid", rsp_valid, m_rv);
    if (m_rv) chk("R9 rsp_data", rsp_data, m_rd);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic send(int op, int ch, int rg, int d);
    while (!cmd_ready) cyc();
    cmd_op = 3'(op); cmd_ch = 1'(ch); cmd_reg = 2'(rg); cmd_data = 8'(d);
    cmd_valid = 1;
    cyc();
    cmd_valid = 0;
  endtask

  task automatic read(int op, int ch, int rg, output int v);
    send(op, ch, rg, 0);
    v = rsp_data;
    cyc();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (3) cyc();
    por_n = 1; cyc(); rst_n = 1; cyc();
    chk("R1 power-on wiper ch0", wiper_pos[7:0], INIT);
    chk("R1 power-on wiper ch1", wiper_pos[15:8], INIT);
    chk("R10 ready idle", cmd_ready, 1);

    send(0, 0, 0, 8'h00);
    chk("R11 low terminal bit0", tap_sel[0], 1);
    send(0, 1, 0, 8'hFF);
    chk("R11 high terminal bit255", tap_sel[TAPS + 255], 1);
    send(6, 1, 0, 1);
    chk("R4 saturate up", wiper_pos[15:8], 8'hFF);
    send(6, 0, 0, 0);
    chk("R4 saturate down", wiper_pos[7:0], 8'h00);
    send(6, 0, 0, 1); send(6, 0, 0, 1);
    chk("R4 step up twice", wiper_pos[7:0], 8'h02);

    wp_n = 0;
    send(2, 0, 1, 8'h33);
    chk("R7 no wip when protected", wip, 0);
    wp_n = 1;
    read(3, 0, 1, v);
    chk("R7 setting unchanged", v, INIT);

    send(2, 0, 1, 8'h33);
    chk("R6 wip rises", wip, 1);
    send(2, 0, 2, 8'h44);
    read(7, 0, 0, v);
    chk("R9 status bit", v, 1);
    n = 3;
    while (wip) begin n++; cyc(); end
    chk("R6 write cycle length", n, WRC);
    send(4, 0, 1, 0);
    chk("R3 recall", wiper_pos[7:0], 8'h33);
    read(3, 0, 2, v);
    chk("R8 write during wip ignored", v, INIT);

    send(0, 1, 0, 8'h5A);
    send(5, 1, 0, 0);
    while (wip) cyc();
    read(3, 1, 0, v);
    chk("R5 save wiper to setting", v, 8'h5A);

    rsp_ready = 0;
    send(1, 1, 0, 0);
    repeat (4) cyc();
    chk("R10 held valid", rsp_valid, 1);
    chk("R10 held data", rsp_data, 8'h5A);
    chk("R10 ready low", cmd_ready, 0);
    rsp_ready = 1; cyc();

    send(0, 1, 0, 8'h11);
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    chk("R1 warm reset ch1 from setting0", wiper_pos[15:8], 8'h5A);
    chk("R1 warm reset ch0 from setting0", wiper_pos[7:0], INIT);
    read(3, 0, 1, v);
    chk("R1 settings kept", v, 8'h33);

    for (int i = 0; i < 4000; i++) begin
      cyc();
      cmd_valid = ($urandom % 3) != 0;
      cmd_op    = 3'($urandom);
      cmd_ch    = 1'($urandom);
      cmd_reg   = 2'($urandom);
      cmd_data  = ($urandom % 4 == 0) ? 8'($urandom % 2) : 8'($urandom);
      rsp_ready = ($urandom % 4) != 0;
      wp_n      = ($urandom % 6) != 0;
      rst_n     = ($urandom % 300) != 0;
    end
    cmd_valid = 0; rst_n = 1;
    repeat (5) cyc();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule